// File: doc/BRIEF.md
# Hierarchical DMA Transfer Sequencer

This block steps one DMA channel through a three-level unit hierarchy: a transaction holds a configurable number of blocks, and each block holds a configurable number of fragments. A hardware request starts work. The selected request mode decides how much of the hierarchy one request runs: one fragment, one block, or the whole transaction. A fourth mode, list mode, also runs a whole transaction per request and marks its end as the end of one list entry. For every fragment the sequencer issues a start pulse to a datapath and waits for that datapath's completion handshake. It then emits single-cycle fragment, block, transaction and list completion pulses.

A sticky interrupt bit is set by the completion levels that a 4-bit interrupt-type code selects, or by an attempt to start with an invalid configuration. The bit is cleared by a write-one-to-clear input. A request that arrives while a unit is still running is held and started once that unit finishes. The position in the hierarchy is kept between requests, so fragment-mode and block-mode requests walk through a transaction step by step.

Top module: `dma_unit_sequencer`

## Requirements
- R1: While reset is held, every output (frag_start, frag_done, blk_done, trans_done, list_done, irq) is 0.
- R2: A request seen in idle with a valid configuration gives a frag_start pulse in the next cycle. A frag_ack accepted while busy gives a frag_done pulse in the next cycle.
- R3: Request mode 0 (fragment) runs exactly one fragment per request. frag_start stays low in the cycle of that fragment's frag_done.
- R4: Request mode 1 (block) runs one full block per request. The next fragment's frag_start comes in the same cycle as the previous frag_done, until the block ends.
- R5: Request modes 2 (transaction) and 3 (list) run all fragments-per-block × blocks-per-transaction fragments per request. list_done pulses together with trans_done only in mode 3.
- R6: blk_done pulses together with every F-th frag_done, where F is fragments per block, counted across requests. trans_done pulses together with the (F×B)-th frag_done, where B is blocks per transaction. The counts then restart.
- R7: A request arriving while busy is held (merged, one deep). Its frag_start follows one cycle after the done pulses that end the running unit.
- R8: A configuration is invalid when fragments per block is 0, blocks per transaction is 0, or the interrupt code is above 8. A request then produces no frag_start and sets irq in the next cycle.
- R9: Interrupt code selects the setting events: 0 none, 1 fragment, 2 block, 3 block or fragment, 4 transaction, 5 transaction or fragment, 6 transaction or block, 7 list, 8 configuration error only. irq rises in the same cycle as the selected done pulse.
- R10: irq holds until a cycle with irq_clr high and is then 0. When a setting event falls in the same cycle as irq_clr, the set wins.
- R11: frag_ack is ignored when idle and in the cycle in which frag_start is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Hardware transfer request, one pulse per request |
| frag_ack | input | 1 | Datapath reports the issued fragment complete |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt bit |
| cfg_frag_cnt | input | FRAG_W | Fragments per block |
| cfg_blk_cnt | input | BLK_W | Blocks per transaction |
| cfg_req_mode | input | 2 | 0 fragment, 1 block, 2 transaction, 3 list |
| cfg_irq_type | input | 4 | Interrupt selection code 0..8 |
| frag_start | output | 1 | Pulse: start one fragment on the datapath |
| frag_done | output | 1 | Pulse: a fragment finished |
| blk_done | output | 1 | Pulse: a block finished |
| trans_done | output | 1 | Pulse: a transaction finished |
| list_done | output | 1 | Pulse: a list-mode transaction finished |
| irq | output | 1 | Sticky interrupt status |

## Verification
Two pairs of events can fall in the same cycle. The first is an interrupt-setting done event meeting an irq_clr pulse. The bench provokes this by raising irq_clr together with the completing frag_ack, and it expects irq to be 1 afterwards. The second is a new request arriving while a unit is finishing. The bench raises hw_req together with a frag_ack inside a block and expects the held request to start exactly one cycle after that block's done pulses, with no further start after the second block.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

    localparam int unsigned IRQ_W        = 4;
    localparam int unsigned IRQ_CODE_MAX = 8;

    typedef enum logic [1:0] {
        RQ_FRAG  = 2'd0,
        RQ_BLOCK = 2'd1,
        RQ_TRANS = 2'd2,
        RQ_LIST  = 2'd3
    } req_mode_e;

    localparam logic [IRQ_W-1:0] IRQ_NONE       = 4'd0;
    localparam logic [IRQ_W-1:0] IRQ_FRAG       = 4'd1;
    localparam logic [IRQ_W-1:0] IRQ_BLK        = 4'd2;
    localparam logic [IRQ_W-1:0] IRQ_BLK_FRAG   = 4'd3;
    localparam logic [IRQ_W-1:0] IRQ_TRANS      = 4'd4;
    localparam logic [IRQ_W-1:0] IRQ_TRANS_FRAG = 4'd5;
    localparam logic [IRQ_W-1:0] IRQ_TRANS_BLK  = 4'd6;
    localparam logic [IRQ_W-1:0] IRQ_LIST       = 4'd7;
    localparam logic [IRQ_W-1:0] IRQ_CFG_ERR    = 4'd8;

    typedef struct packed {
        logic busy;
        logic pending;
        logic frag_start;
        logic frag_done;
        logic blk_done;
        logic trans_done;
        logic list_done;
        logic irq;
    } seq_state_t;

endpackage

// File: rtl/seq_wrap_counter.sv
`timescale 1ns/1ps
module seq_wrap_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == (limit - 1'b1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/seq_irq_select.sv
`timescale 1ns/1ps
module seq_irq_select
    import dma_seq_pkg::*;
(
    input  logic [IRQ_W-1:0] irq_type,
    input  logic             ev_frag,
    input  logic             ev_blk,
    input  logic             ev_trans,
    input  logic             ev_list,
    output logic             hit
);
    always_comb begin
        unique case (irq_type)
            IRQ_FRAG:       hit = ev_frag;
            IRQ_BLK:        hit = ev_blk;
            IRQ_BLK_FRAG:   hit = ev_blk | ev_frag;
            IRQ_TRANS:      hit = ev_trans;
            IRQ_TRANS_FRAG: hit = ev_trans | ev_frag;
            IRQ_TRANS_BLK:  hit = ev_trans | ev_blk;
            IRQ_LIST:       hit = ev_list;
            default:        hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_unit_sequencer.sv
`timescale 1ns/1ps
module dma_unit_sequencer
    import dma_seq_pkg::*;
#(
    parameter int unsigned FRAG_W = 8,
    parameter int unsigned BLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_req,
    input  logic              frag_ack,
    input  logic              irq_clr,
    input  logic [FRAG_W-1:0] cfg_frag_cnt,
    input  logic [BLK_W-1:0]  cfg_blk_cnt,
    input  logic [1:0]        cfg_req_mode,
    input  logic [IRQ_W-1:0]  cfg_irq_type,
    output logic              frag_start,
    output logic              frag_done,
    output logic              blk_done,
    output logic              trans_done,
    output logic              list_done,
    output logic              irq
);
    seq_state_t st_d, st_q;

    logic cfg_ok, start_req, start_ok, cfg_fault;
    logic ack_ok, ev_blk, ev_trans, ev_list, unit_end;
    logic frag_last, blk_last, irq_hit;

    // Hierarchy position: fragment index inside the block, block index inside the transaction
    seq_wrap_counter #(.W(FRAG_W)) u_frag_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ack_ok),
        .clear (cfg_fault),
        .limit (cfg_frag_cnt),
        .last  (frag_last)
    );

    seq_wrap_counter #(.W(BLK_W)) u_blk_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ack_ok & frag_last),
        .clear (cfg_fault),
        .limit (cfg_blk_cnt),
        .last  (blk_last)
    );

    seq_irq_select u_irq_sel (
        .irq_type (cfg_irq_type),
        .ev_frag  (ack_ok),
        .ev_blk   (ev_blk),
        .ev_trans (ev_trans),
        .ev_list  (ev_list),
        .hit      (irq_hit)
    );

    always_comb begin
        cfg_ok    = (cfg_frag_cnt != '0) && (cfg_blk_cnt != '0)
                    && (cfg_irq_type <= IRQ_W'(IRQ_CODE_MAX));
        // a fragment issued in this cycle cannot complete in this cycle
        ack_ok    = st_q.busy && !st_q.frag_start && frag_ack;
        ev_blk    = ack_ok && frag_last;
        ev_trans  = ev_blk && blk_last;
        ev_list   = ev_trans && (cfg_req_mode == RQ_LIST);

        unique case (cfg_req_mode)
            RQ_FRAG:  unit_end = ack_ok;
            RQ_BLOCK: unit_end = ev_blk;
            default:  unit_end = ev_trans;
        endcase

        start_req = !st_q.busy && (hw_req || st_q.pending);
        start_ok  = start_req && cfg_ok;
        cfg_fault = start_req && !cfg_ok;

        st_d            = st_q;
        st_d.busy       = st_q.busy ? !unit_end : start_ok;
        st_d.pending    = st_q.busy ? (st_q.pending || hw_req) : 1'b0;
        st_d.frag_start = start_ok || (ack_ok && !unit_end);
        st_d.frag_done  = ack_ok;
        st_d.blk_done   = ev_blk;
        st_d.trans_done = ev_trans;
        st_d.list_done  = ev_list;
        st_d.irq        = (st_q.irq && !irq_clr) || irq_hit || cfg_fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frag_start = st_q.frag_start;
    assign frag_done  = st_q.frag_done;
    assign blk_done   = st_q.blk_done;
    assign trans_done = st_q.trans_done;
    assign list_done  = st_q.list_done;
    assign irq        = st_q.irq;

    // ---------------- assertions ----------------
    assert_blk_has_frag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> frag_done);

    assert_trans_has_blk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trans_done |-> blk_done);

    assert_list_only_list_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        list_done |-> (trans_done && cfg_req_mode == RQ_LIST));

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_no_back_to_back_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frag_done |=> !frag_done);

    assert_bad_cfg_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && hw_req && (cfg_frag_cnt == '0 || cfg_blk_cnt == '0))
        |=> (!frag_start && irq));
endmodule

// File: tb/dma_unit_sequencer_tb_top.sv
`timescale 1ns/1ps
module dma_unit_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, hw_req, frag_ack, irq_clr;
    logic [7:0] f_cnt, b_cnt;
    logic [1:0] mode;
    logic [3:0] ityp;
    logic       frag_start, frag_done, blk_done, trans_done, list_done, irq;
    int         errs = 0, checks = 0;

    always #2.5 clk = ~clk;

    dma_unit_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .frag_ack(frag_ack), .irq_clr(irq_clr),
        .cfg_frag_cnt(f_cnt), .cfg_blk_cnt(b_cnt), .cfg_req_mode(mode), .cfg_irq_type(ityp),
        .frag_start(frag_start), .frag_done(frag_done), .blk_done(blk_done),
        .trans_done(trans_done), .list_done(list_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s F=%0d B=%0d mode=%0d type=%0d act=%0b exp=%0b",
                     tag, f_cnt, b_cnt, mode, ityp, act, exp);
        end
    endtask

    function automatic logic exp_hit(input int t, input logic f, input logic b,
                                     input logic tr, input logic l);
        case (t)
            1: return f;
            2: return b;
            3: return b | f;
            4: return tr;
            5: return tr | f;
            6: return tr | b;
            7: return l;
            default: return 1'b0;
        endcase
    endfunction

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic start_req;
        hw_req = 1'b1;
        tick;
        hw_req = 1'b0;
        chk("R2 frag_start after request", frag_start, 1'b1);
    endtask

    // precondition: at a negedge where frag_start has just been seen high
    task automatic do_frag(input int g, input logic extra, input logic clr_with,
                           output logic cont);
        int   F, B;
        logic eb, et, el, ue;
        F = int'(f_cnt);
        B = int'(b_cnt);
        tick;
        irq_clr  = clr_with;
        frag_ack = 1'b1;
        hw_req   = extra;
        tick;
        frag_ack = 1'b0;
        hw_req   = 1'b0;
        irq_clr  = 1'b0;
        eb = ((g % F) == F - 1);
        et = (g == F * B - 1);
        el = et && (mode == 2'd3);
        ue = (mode == 2'd0) ? 1'b1 : (mode == 2'd1) ? eb : et;
        chk("R2 frag_done", frag_done, 1'b1);
        chk("R6 blk_done", blk_done, eb);
        chk("R6 trans_done", trans_done, et);
        chk("R5 list_done", list_done, el);
        chk("R9 irq select", irq, exp_hit(int'(ityp), 1'b1, eb, et, el));
        chk("R3/R4 next frag_start", frag_start, !ue);
        cont    = !ue;
        irq_clr = 1'b1;
    endtask

    task automatic tail;
        tick;
        irq_clr = 1'b0;
        chk("R10 irq cleared", irq, 1'b0);
        chk("R3 idle after unit", frag_start, 1'b0);
    endtask

    initial begin
        logic cont;
        int   g;
        rst_n = 1'b0; hw_req = 1'b0; frag_ack = 1'b0; irq_clr = 1'b0;
        f_cnt = 8'd1; b_cnt = 8'd1; mode = 2'd0; ityp = 4'd0;
        repeat (3) tick;
        chk("R1 frag_start reset", frag_start, 1'b0);
        chk("R1 frag_done reset", frag_done, 1'b0);
        chk("R1 blk_done reset", blk_done, 1'b0);
        chk("R1 trans_done reset", trans_done, 1'b0);
        chk("R1 list_done reset", list_done, 1'b0);
        chk("R1 irq reset", irq, 1'b0);
        rst_n = 1'b1;
        tick;

        // sweep: every mode, every interrupt code, small hierarchy sizes
        for (int fi = 1; fi <= 3; fi++) begin
            for (int bi = 1; bi <= 3; bi++) begin
                for (int mi = 0; mi < 4; mi++) begin
                    for (int ti = 0; ti <= 8; ti++) begin
                        f_cnt = 8'(fi); b_cnt = 8'(bi); mode = 2'(mi); ityp = 4'(ti);
                        g = 0;
                        while (g < fi * bi) begin
                            start_req;
                            cont = 1'b1;
                            while (cont) begin
                                do_frag(g, 1'b0, 1'b0, cont);
                                g++;
                            end
                            tail;
                        end
                    end
                end
            end
        end

        // R11: ack ignored when idle and in the issue cycle
        f_cnt = 8'd2; b_cnt = 8'd1; mode = 2'd2; ityp = 4'd1;
        frag_ack = 1'b1;
        tick;
        frag_ack = 1'b0;
        chk("R11 idle ack ignored", frag_done, 1'b0);
        hw_req = 1'b1;
        tick;
        hw_req = 1'b0;
        chk("R2 frag_start", frag_start, 1'b1);
        frag_ack = 1'b1;
        tick;
        frag_ack = 1'b0;
        chk("R11 ack in issue cycle ignored", frag_done, 1'b0);
        chk("R11 no irq from ignored ack", irq, 1'b0);
        do_frag(0, 1'b0, 1'b0, cont);
        do_frag(1, 1'b0, 1'b0, cont);
        tail;

        // R7: request while busy is held and started after the block ends
        f_cnt = 8'd2; b_cnt = 8'd2; mode = 2'd1; ityp = 4'd2;
        start_req;
        do_frag(0, 1'b1, 1'b0, cont);
        do_frag(1, 1'b0, 1'b0, cont);
        tick;
        irq_clr = 1'b0;
        chk("R7 held request starts", frag_start, 1'b1);
        do_frag(2, 1'b0, 1'b0, cont);
        do_frag(3, 1'b0, 1'b0, cont);
        tail;

        // R10: set wins over simultaneous clear; bit is sticky
        f_cnt = 8'd1; b_cnt = 8'd1; mode = 2'd2; ityp = 4'd1;
        start_req;
        do_frag(0, 1'b0, 1'b1, cont);
        irq_clr = 1'b0;
        tick;
        tick;
        chk("R10 irq sticky", irq, 1'b1);
        irq_clr = 1'b1;
        tick;
        irq_clr = 1'b0;
        chk("R10 irq cleared by W1C", irq, 1'b0);

        // R8: invalid configurations
        for (int k = 0; k < 3; k++) begin
            f_cnt = (k == 0) ? 8'd0 : 8'd1;
            b_cnt = (k == 1) ? 8'd0 : 8'd1;
            ityp  = (k == 2) ? 4'd9 : 4'd0;
            mode  = 2'd2;
            hw_req = 1'b1;
            tick;
            hw_req = 1'b0;
            chk("R8 no start on bad config", frag_start, 1'b0);
            chk("R8 irq on bad config", irq, 1'b1);
            irq_clr = 1'b1;
            tick;
            irq_clr = 1'b0;
            chk("R8 still idle", frag_start, 1'b0);
            chk("R10 irq cleared", irq, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R2 act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule